// File: doc/BRIEF.md
# CAN Transmit Request Handshake

This block sits between a software-facing message interface and a bit-level CAN framer. A user presents one message object: a 29-bit identifier field, an extended-format flag, a remote flag, a 4-bit length code and 64 bits of payload. The user then raises a level request and holds it. The block waits until it is in run mode and the bus is idle. It then issues a single-cycle start command to the framer, together with a registered copy of the message in normalized form. In that copy a standard identifier is moved down to the low bits, the byte count is limited, and unused payload bytes are cleared.

The framer reports the result of the attempt. A clean finish produces a one-cycle ready pulse to the user, who then releases the request. An arbitration loss or any bus error ends the attempt without a ready pulse. The user may then withdraw the request, or keep it high, in which case the block retries at the next idle bus.

A stop/run control runs alongside. After reset the block waits for initial bus synchronization and then parks in stop. A clear-stop event puts it in run mode. A set-stop event is held as pending until the bus is idle and no transmission is in flight, and only then is the stop granted.

Top module: `can_tx_handshake`

## Requirements
- R1: While reset is high, and after reset until `sync_done_i` is sampled high, `stop_gnt_o`, `stop_pend_o`, `tx_rdy_o` and `fr_start_o` are 0. One cycle after `sync_done_i` is sampled high, `stop_gnt_o` is 1.
- R2: `fr_start_o` is a one-cycle pulse. It is issued only in run mode, with the request high, no stop pending, and `bus_idle_i` high in the cycle before the pulse.
- R3: With `tx_ide_i`=0, `fr_id_o` equals 18 zero bits followed by `tx_id_i[28:18]`. With `tx_ide_i`=1, `fr_id_o` equals `tx_id_i`.
- R4: `fr_dlc_o` repeats the length code unchanged. `fr_nbytes_o` is the length code for codes 0 to 8, is 8 for codes 9 to 15, and is 0 whenever the remote flag is 1.
- R5: In `fr_data_o`, payload byte k (k=0 first) sits at bits [63-8k -: 8]. Bytes with k not below `fr_nbytes_o` are zero. All `fr_*` fields stay constant from one start pulse to the next.
- R6: `tx_rdy_o` pulses for one cycle, in the cycle after `fr_done_i` is sampled high during a transmission with no error or arbitration loss in that same cycle. A request still held high after the pulse does not cause another start.
- R7: An error (`fr_err_i`) or arbitration loss (`fr_arb_lost_i`) during a transmission produces no ready pulse. If the request stays high, a new start with the current message follows at the next idle bus, and never while the bus is busy.
- R8: A request dropped before a start is issued, or after an error or arbitration loss, is cancelled with no start and no ready pulse.
- R9: `stop_set_i` in run mode raises `stop_pend_o` in the next cycle. Stop is granted only when the bus is idle and no transmission is active. `stop_pend_o` returns to 0 as the grant rises.
- R10: `stop_clr_i` in stop mode drops `stop_gnt_o` in the next cycle. In run mode it clears a pending stop, and it wins over a `stop_set_i` in the same cycle. It has no effect before initial synchronization.
- R11: While stop is granted, a held request never produces a start. A request still held when run mode returns is then sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_req_i | input | 1 | Level transmit request |
| tx_id_i | input | 29 | Identifier field; standard ID in bits [28:18] |
| tx_ide_i | input | 1 | 1 = extended identifier |
| tx_rtr_i | input | 1 | 1 = remote frame |
| tx_dlc_i | input | 4 | Length code |
| tx_data_i | input | 64 | Payload, first byte in [63:56] |
| tx_rdy_o | output | 1 | One-cycle success pulse |
| stop_set_i | input | 1 | Stop request event |
| stop_clr_i | input | 1 | Run request event |
| stop_pend_o | output | 1 | Stop requested, not yet granted |
| stop_gnt_o | output | 1 | Controller stopped |
| bus_idle_i | input | 1 | Bus is idle |
| sync_done_i | input | 1 | Initial bus synchronization finished |
| fr_start_o | output | 1 | Start command to framer |
| fr_id_o | output | 29 | Normalized identifier |
| fr_ide_o | output | 1 | Extended flag to framer |
| fr_rtr_o | output | 1 | Remote flag to framer |
| fr_dlc_o | output | 4 | Length code as sent |
| fr_nbytes_o | output | 4 | Payload bytes to send (0 to 8) |
| fr_data_o | output | 64 | Payload with unused bytes cleared |
| fr_done_i | input | 1 | Framer: frame sent without error |
| fr_err_i | input | 1 | Framer: bus error during frame |
| fr_arb_lost_i | input | 1 | Framer: arbitration lost |

## Verification
The bench targets the limit cases of normalization: length codes 8, 9 and 15, remote frames with a large code, and standard identifiers with stray low bits. A design that got these wrong would send more than eight bytes, leak payload into cleared bytes, or leak bits 17:0 into a standard identifier. It also holds the request high after the ready pulse, and keeps the bus busy after an error. A faulty sequencer would send the frame twice in the first case, and start in the middle of someone else's frame in the second. The stop tests place the stop request during a live transmission and fire set and clear together. A wrong controller would then cut a frame short, or lose the clear.

// File: rtl/txh_pkg.sv
package txh_pkg;

    localparam int ID_W      = 29;
    localparam int STD_W     = 11;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int NB_W      = $clog2(MAX_BYTES + 1);

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_STOP,
        ST_IDLE,
        ST_WAIT,
        ST_ACTIVE,
        ST_HOLD
    } txh_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } txh_msg_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [NB_W-1:0]   nbytes;
        logic [DATA_W-1:0] data;
    } txh_frame_t;

    function automatic logic [NB_W-1:0] payload_len(input logic [DLC_W-1:0] code,
                                                   input logic remote);
        logic [NB_W-1:0] len;
        if (remote)
            len = '0;
        else if (int'(code) > MAX_BYTES)
            len = NB_W'(MAX_BYTES);
        else
            len = NB_W'(code);
        return len;
    endfunction

    function automatic logic [ID_W-1:0] place_id(input logic [ID_W-1:0] raw,
                                                input logic extended);
        logic [ID_W-1:0] v;
        if (extended)
            v = raw;
        else
            v = {{(ID_W-STD_W){1'b0}}, raw[ID_W-1 -: STD_W]};
        return v;
    endfunction

endpackage

// File: rtl/txh_norm.sv
module txh_norm
    import txh_pkg::*;
(
    input  txh_msg_t   msg,
    output txh_frame_t frm
);

    logic [NB_W-1:0]   len;
    logic [DATA_W-1:0] masked;

    assign len = payload_len(msg.dlc, msg.rtr);

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        assign masked[DATA_W-1-8*b -: 8] =
            (NB_W'(b) < len) ? msg.data[DATA_W-1-8*b -: 8] : 8'h00;
    end

    always_comb begin
        frm.id     = place_id(msg.id, msg.ide);
        frm.ide    = msg.ide;
        frm.rtr    = msg.rtr;
        frm.dlc    = msg.dlc;
        frm.nbytes = len;
        frm.data   = masked;
    end

endmodule

// File: rtl/txh_stop.sv
module txh_stop (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic running,
    input  logic granting,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst || clr_ev || granting || !running)
            pend <= 1'b0;
        else if (set_ev)
            pend <= 1'b1;
    end

endmodule

// File: rtl/txh_seq.sv
module txh_seq
    import txh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic bus_idle,
    input  logic sync_done,
    input  logic clr_ev,
    input  logic pend,
    input  logic done,
    input  logic err,
    input  logic arb_lost,
    output logic launch,
    output logic granting,
    output logic running,
    output logic start,
    output logic rdy,
    output logic stopped
);

    txh_state_e st, st_nxt;
    logic       stop_due;
    logic       fault;

    assign stop_due = pend && !clr_ev && bus_idle;
    assign fault    = err || arb_lost;

    always_comb begin
        st_nxt   = st;
        launch   = 1'b0;
        granting = 1'b0;
        unique case (st)
            ST_SYNC: if (sync_done) st_nxt = ST_STOP;
            ST_STOP: if (clr_ev)    st_nxt = ST_IDLE;
            ST_IDLE: begin
                if (stop_due) begin
                    st_nxt   = ST_STOP;
                    granting = 1'b1;
                end else if (req) begin
                    st_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (stop_due) begin
                    st_nxt   = ST_STOP;
                    granting = 1'b1;
                end else if (!req) begin
                    st_nxt = ST_IDLE;
                end else if (bus_idle) begin
                    st_nxt = ST_ACTIVE;
                    launch = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (fault)     st_nxt = ST_WAIT;
                else if (done) st_nxt = ST_HOLD;
            end
            ST_HOLD: if (!req) st_nxt = ST_IDLE;
            default: st_nxt = ST_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_SYNC;
            start <= 1'b0;
            rdy   <= 1'b0;
        end else begin
            st    <= st_nxt;
            start <= launch;
            rdy   <= (st == ST_ACTIVE) && done && !fault;
        end
    end

    assign stopped = (st == ST_STOP);
    assign running = (st != ST_SYNC) && (st != ST_STOP);

endmodule

// File: rtl/can_tx_handshake.sv
module can_tx_handshake
    import txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_req_i,
    input  logic [ID_W-1:0]   tx_id_i,
    input  logic              tx_ide_i,
    input  logic              tx_rtr_i,
    input  logic [DLC_W-1:0]  tx_dlc_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_rdy_o,
    input  logic              stop_set_i,
    input  logic              stop_clr_i,
    output logic              stop_pend_o,
    output logic              stop_gnt_o,
    input  logic              bus_idle_i,
    input  logic              sync_done_i,
    output logic              fr_start_o,
    output logic [ID_W-1:0]   fr_id_o,
    output logic              fr_ide_o,
    output logic              fr_rtr_o,
    output logic [DLC_W-1:0]  fr_dlc_o,
    output logic [NB_W-1:0]   fr_nbytes_o,
    output logic [DATA_W-1:0] fr_data_o,
    input  logic              fr_done_i,
    input  logic              fr_err_i,
    input  logic              fr_arb_lost_i
);

    txh_msg_t   msg_in;
    txh_frame_t frm_nxt;
    txh_frame_t frm_q;
    logic       launch;
    logic       granting;
    logic       running;
    logic       pend;

    assign msg_in = '{id: tx_id_i, ide: tx_ide_i, rtr: tx_rtr_i,
                      dlc: tx_dlc_i, data: tx_data_i};

    txh_norm u_norm (
        .msg (msg_in),
        .frm (frm_nxt)
    );

    txh_stop u_stop (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (stop_set_i),
        .clr_ev   (stop_clr_i),
        .running  (running),
        .granting (granting),
        .pend     (pend)
    );

    txh_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (tx_req_i),
        .bus_idle  (bus_idle_i),
        .sync_done (sync_done_i),
        .clr_ev    (stop_clr_i),
        .pend      (pend),
        .done      (fr_done_i),
        .err       (fr_err_i),
        .arb_lost  (fr_arb_lost_i),
        .launch    (launch),
        .granting  (granting),
        .running   (running),
        .start     (fr_start_o),
        .rdy       (tx_rdy_o),
        .stopped   (stop_gnt_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            frm_q <= '0;
        else if (launch)
            frm_q <= frm_nxt;
    end

    assign stop_pend_o = pend;
    assign fr_id_o     = frm_q.id;
    assign fr_ide_o    = frm_q.ide;
    assign fr_rtr_o    = frm_q.rtr;
    assign fr_dlc_o    = frm_q.dlc;
    assign fr_nbytes_o = frm_q.nbytes;
    assign fr_data_o   = frm_q.data;

endmodule

// File: rtl/txh_checker.sv
module txh_checker
    import txh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_idle_i,
    input logic              fr_start_o,
    input logic              fr_done_i,
    input logic              fr_err_i,
    input logic              fr_arb_lost_i,
    input logic              fr_rtr_o,
    input logic [NB_W-1:0]   fr_nbytes_o,
    input logic [ID_W-1:0]   fr_id_o,
    input logic [DLC_W-1:0]  fr_dlc_o,
    input logic              tx_rdy_o,
    input logic              stop_gnt_o,
    input logic              stop_pend_o
);

    AST_START_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        fr_start_o |-> $past(bus_idle_i)); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        fr_start_o |=> !fr_start_o); // R2
    AST_NBYTES_CAP: assert property (@(posedge clk) disable iff (rst)
        fr_start_o |-> (int'(fr_nbytes_o) <= MAX_BYTES)); // R4
    AST_REMOTE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fr_start_o && fr_rtr_o) |-> (fr_nbytes_o == '0)); // R4
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        !fr_start_o |-> ($stable(fr_id_o) && $stable(fr_dlc_o))); // R5
    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        tx_rdy_o |-> ($past(fr_done_i) && !$past(fr_err_i) && !$past(fr_arb_lost_i))); // R6
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_rdy_o |=> !tx_rdy_o); // R6
    AST_GRANT_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($rose(stop_gnt_o) && $past(stop_pend_o)) |-> $past(bus_idle_i)); // R9
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_gnt_o) |-> !stop_pend_o); // R9
    AST_NO_START_STOPPED: assert property (@(posedge clk) disable iff (rst)
        stop_gnt_o |-> !fr_start_o); // R11

endmodule

bind can_tx_handshake txh_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_idle_i    (bus_idle_i),
    .fr_start_o    (fr_start_o),
    .fr_done_i     (fr_done_i),
    .fr_err_i      (fr_err_i),
    .fr_arb_lost_i (fr_arb_lost_i),
    .fr_rtr_o      (fr_rtr_o),
    .fr_nbytes_o   (fr_nbytes_o),
    .fr_id_o       (fr_id_o),
    .fr_dlc_o      (fr_dlc_o),
    .tx_rdy_o      (tx_rdy_o),
    .stop_gnt_o    (stop_gnt_o),
    .stop_pend_o   (stop_pend_o)
);

// File: tb/tb_can_tx_handshake.sv
module tb_can_tx_handshake;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_req_i = 1'b0;
    logic [28:0] tx_id_i = '0;
    logic        tx_ide_i = 1'b0;
    logic        tx_rtr_i = 1'b0;
    logic [3:0]  tx_dlc_i = '0;
    logic [63:0] tx_data_i = '0;
    logic        tx_rdy_o;
    logic        stop_set_i = 1'b0;
    logic        stop_clr_i = 1'b0;
    logic        stop_pend_o;
    logic        stop_gnt_o;
    logic        bus_idle_i = 1'b1;
    logic        sync_done_i = 1'b0;
    logic        fr_start_o;
    logic [28:0] fr_id_o;
    logic        fr_ide_o;
    logic        fr_rtr_o;
    logic [3:0]  fr_dlc_o;
    logic [3:0]  fr_nbytes_o;
    logic [63:0] fr_data_o;
    logic        fr_done_i = 1'b0;
    logic        fr_err_i = 1'b0;
    logic        fr_arb_lost_i = 1'b0;

    always #2 clk = ~clk;

    can_tx_handshake dut (.*);

    int checks = 0;
    int failures = 0;
    int starts = 0;
    int rdys = 0;

    always @(negedge clk) begin
        if (fr_start_o) starts++;
        if (tx_rdy_o)   rdys++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] e_id(input logic [28:0] id, input logic ide);
        return ide ? id : {18'd0, id[28:18]};
    endfunction

    function automatic int e_nb(input logic [3:0] dlc, input logic rtr);
        if (rtr) return 0;
        return (dlc > 4'd8) ? 8 : int'(dlc);
    endfunction

    function automatic logic [63:0] e_data(input logic [63:0] d, input int nb);
        logic [63:0] r = '0;
        for (int k = 0; k < nb; k++) r[63-8*k -: 8] = d[63-8*k -: 8];
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start(output bit seen);
        int base = starts;
        seen = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            tick(1);
            if (starts != base) seen = 1'b1;
        end
    endtask

    task automatic check_fields(input string tag);
        int nb = e_nb(tx_dlc_i, tx_rtr_i);
        chk(fr_id_o == e_id(tx_id_i, tx_ide_i), {tag, " R3 id"}, 64'(fr_id_o),
            64'(e_id(tx_id_i, tx_ide_i)));
        chk(fr_dlc_o == tx_dlc_i && fr_ide_o == tx_ide_i && fr_rtr_o == tx_rtr_i,
            {tag, " R4 dlc"}, 64'(fr_dlc_o), 64'(tx_dlc_i));
        chk(int'(fr_nbytes_o) == nb, {tag, " R4 nbytes"}, 64'(fr_nbytes_o), 64'(nb));
        chk(fr_data_o == e_data(tx_data_i, nb), {tag, " R5 data"}, fr_data_o,
            e_data(tx_data_i, nb));
    endtask

    task automatic set_msg(input logic [28:0] id, input logic ide, input logic rtr,
                           input logic [3:0] dlc, input logic [63:0] d);
        tx_id_i = id; tx_ide_i = ide; tx_rtr_i = rtr; tx_dlc_i = dlc; tx_data_i = d;
    endtask

    task automatic finish_ok(input string tag);
        int r0;
        fr_done_i = 1'b1;
        tick(1);
        fr_done_i = 1'b0;
        chk(tx_rdy_o == 1'b1, {tag, " R6 rdy pulse"}, 64'(tx_rdy_o), 64'd1);
        tick(1);
        chk(tx_rdy_o == 1'b0, {tag, " R6 rdy one cycle"}, 64'(tx_rdy_o), 64'd0);
        r0 = starts;
        tick(3);
        chk(starts == r0, {tag, " R6 no resend while held"}, 64'(starts), 64'(r0));
        tx_req_i = 1'b0;
        tick(1);
    endtask

    task automatic send_one(input string tag);
        bit seen;
        tx_req_i = 1'b1;
        wait_start(seen);
        chk(seen, {tag, " R2 start issued"}, 64'(seen), 64'd1);
        check_fields(tag);
        tick(1);
        chk(fr_start_o == 1'b0, {tag, " R2 start pulse"}, 64'(fr_start_o), 64'd0);
    endtask

    initial begin
        bit seen;
        int s0, r0, pick;
        void'($urandom(32'h5EED_CA11));

        tick(3);
        chk(!stop_gnt_o && !stop_pend_o && !tx_rdy_o && !fr_start_o, "R1 reset state",
            {stop_gnt_o, stop_pend_o, tx_rdy_o, fr_start_o}, 0);
        rst = 1'b0;
        stop_clr_i = 1'b1;
        tick(1);
        stop_clr_i = 1'b0;
        tick(2);
        chk(stop_gnt_o == 1'b0, "R1 R10 no grant before sync", 64'(stop_gnt_o), 0);
        sync_done_i = 1'b1;
        tick(1);
        sync_done_i = 1'b0;
        chk(stop_gnt_o == 1'b1, "R1 stop after sync", 64'(stop_gnt_o), 1);

        set_msg(29'h1ABCDEF0, 1'b1, 1'b0, 4'd3, 64'h1122334455667788);
        tx_req_i = 1'b1;
        s0 = starts;
        tick(5);
        chk(starts == s0, "R11 no start while stopped", 64'(starts), 64'(s0));
        stop_clr_i = 1'b1;
        tick(1);
        stop_clr_i = 1'b0;
        chk(stop_gnt_o == 1'b0, "R10 clear leaves stop", 64'(stop_gnt_o), 0);
        wait_start(seen);
        chk(seen, "R11 held request sent after run", 64'(seen), 1);
        check_fields("held");
        finish_ok("held");

        set_msg(29'h1FFFFFFF, 1'b0, 1'b0, 4'd15, 64'hA1A2A3A4A5A6A7A8);
        send_one("dlc15 std");
        finish_ok("dlc15 std");
        set_msg(29'h00040001, 1'b0, 1'b1, 4'd9, 64'hFFFFFFFFFFFFFFFF);
        send_one("rtr dlc9");
        finish_ok("rtr dlc9");
        set_msg(29'h0ABCDE12, 1'b1, 1'b0, 4'd8, 64'h0102030405060708);
        send_one("dlc8 ext");
        finish_ok("dlc8 ext");
        set_msg(29'h0ABCDE12, 1'b0, 1'b0, 4'd0, 64'h0102030405060708);
        send_one("dlc0");
        finish_ok("dlc0");

        for (int n = 0; n < 40; n++) begin
            set_msg(29'($urandom), 1'($urandom), 1'(($urandom % 4) == 0),
                    4'($urandom), {$urandom, $urandom});
            bus_idle_i = 1'b1;
            send_one("rand");
            pick = $urandom % 3;
            if (pick == 0) begin
                finish_ok("rand");
            end else if (pick == 1) begin
                if (($urandom % 2) == 0) fr_err_i = 1'b1; else fr_arb_lost_i = 1'b1;
                bus_idle_i = 1'b0;
                r0 = rdys;
                s0 = starts;
                tick(1);
                fr_err_i = 1'b0; fr_arb_lost_i = 1'b0;
                tick(3);
                chk(rdys == r0, "R7 no rdy after error", 64'(rdys), 64'(r0));
                chk(starts == s0, "R7 no retry while busy", 64'(starts), 64'(s0));
                bus_idle_i = 1'b1;
                wait_start(seen);
                chk(seen, "R7 retry at idle", 64'(seen), 1);
                check_fields("retry");
                finish_ok("retry");
            end else begin
                fr_arb_lost_i = 1'b1;
                r0 = rdys;
                s0 = starts;
                tick(1);
                fr_arb_lost_i = 1'b0;
                tx_req_i = 1'b0;
                tick(5);
                chk(starts == s0 && rdys == r0, "R8 withdraw after arb loss",
                    64'(starts), 64'(s0));
            end
        end

        bus_idle_i = 1'b0;
        tx_req_i = 1'b1;
        s0 = starts;
        tick(4);
        tx_req_i = 1'b0;
        tick(1);
        bus_idle_i = 1'b1;
        tick(5);
        chk(starts == s0, "R8 cancel while waiting", 64'(starts), 64'(s0));

        bus_idle_i = 1'b0;
        stop_set_i = 1'b1;
        tick(1);
        stop_set_i = 1'b0;
        chk(stop_pend_o == 1'b1, "R9 pending raised", 64'(stop_pend_o), 1);
        tick(3);
        chk(stop_gnt_o == 1'b0, "R9 no grant while busy", 64'(stop_gnt_o), 0);
        bus_idle_i = 1'b1;
        tick(1);
        chk(stop_gnt_o == 1'b1 && stop_pend_o == 1'b0, "R9 grant at idle",
            {stop_gnt_o, stop_pend_o}, 64'h2);
        stop_clr_i = 1'b1;
        tick(1);
        stop_clr_i = 1'b0;

        set_msg(29'h12345678, 1'b1, 1'b0, 4'd2, 64'hDEADBEEFCAFEF00D);
        send_one("stop mid");
        stop_set_i = 1'b1;
        tick(1);
        stop_set_i = 1'b0;
        tick(3);
        chk(stop_gnt_o == 1'b0, "R9 no grant during frame", 64'(stop_gnt_o), 0);
        fr_done_i = 1'b1;
        tick(1);
        fr_done_i = 1'b0;
        chk(tx_rdy_o == 1'b1, "R6 rdy with stop pending", 64'(tx_rdy_o), 1);
        tx_req_i = 1'b0;
        tick(3);
        chk(stop_gnt_o == 1'b1, "R9 grant after frame", 64'(stop_gnt_o), 1);
        stop_clr_i = 1'b1;
        tick(1);
        stop_clr_i = 1'b0;

        bus_idle_i = 1'b0;
        stop_set_i = 1'b1;
        stop_clr_i = 1'b1;
        tick(1);
        stop_set_i = 1'b0;
        stop_clr_i = 1'b0;
        chk(stop_pend_o == 1'b0, "R10 clear wins over set", 64'(stop_pend_o), 0);

        stop_set_i = 1'b1;
        tick(1);
        stop_set_i = 1'b0;
        tx_req_i = 1'b1;
        s0 = starts;
        bus_idle_i = 1'b1;
        tick(4);
        chk(starts == s0 && stop_gnt_o, "R2 pending stop blocks start", 64'(starts), 64'(s0));
        stop_clr_i = 1'b1;
        tick(1);
        stop_clr_i = 1'b0;
        wait_start(seen);
        chk(seen, "R11 start after run restored", 64'(seen), 1);
        finish_ok("final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule